// File: doc/BRIEF.md
# Incremental Encoder Counter Channel

This block is a single counting channel for an incremental position encoder. It can also serve as a general event counter. Three track inputs (A, B and the reference track C) are decoded in one of four evaluation modes. The first mode is a plain clock-and-direction counter. The other three are quadrature modes that count once, twice or four times per signal period. The result updates a wrapping counter.

A mode word selects the evaluation, an optional reversal of the count direction, and an optional inversion of both A and B. The inversion moves the quadrant in which a reference pulse on C is accepted. The same word picks a hardware source that clears or reloads the counter, and a hardware source for each of two capture registers.

A one-shot control write issues software clear, load, capture and reference-arm commands. After an arm, the channel tracks the first and the second accepted reference so that sources can act on a chosen reference mark. The load value and the captured values travel through a narrow data word, one slice at a time. Event inputs (timer tick, sync, software sync, the two external inputs) are single-cycle strobes that arrive already synchronized to `clk`.

Top module: `qc_channel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, the count, the load register, both capture registers and the mode word are all zero, and the reference sequencer is unarmed.
- R2: In evaluation mode 0 (mode bits [1:0] = 0), every rising edge of track B counts one step. The step is up while track A is 0 and down while track A is 1. Track A edges alone never count.
- R3: The quadrature forward order of (A,B) is 00, 10, 11, 01, 00. In 4x mode (bits [1:0] = 3), every legal transition counts: forward steps count up, backward steps count down. The count changes at the clock edge that first samples the new track levels.
- R4: In 2x mode (bits [1:0] = 2), only transitions in which A changes count, so a full forward period adds 2. In 1x mode (bits [1:0] = 1), only the transitions between 00 and 10 count, so a full period moves the count by exactly 1 in its direction.
- R5: In a quadrature mode, a transition in which A and B change in the same cycle does not change the count.
- R6: Mode bit 2 reverses the count direction in every evaluation mode.
- R7: A reference is a rising edge of C. In a quadrature mode, it is accepted only while the (possibly inverted) tracks are A=1 and B=1. With mode bit 3 = 0 this means raw A=B=1; with bit 3 = 1, raw A and B are both inverted, so this means raw A=B=0. In mode 0, every rising edge of C is a reference.
- R8: A load-register write (word 0 = bits 15:0, word 1 = bits 31:16) never changes the count. A control write with bit 0 clears the count, and with bit 1 copies the load register into it. Clear wins over load; software commands win over hardware sources, and hardware sources win over track steps.
- R9: The count wraps modulo 2^32: one up step from 0xFFFFFFFF gives 0, and one down step from 0 gives 0xFFFFFFFF.
- R10: Mode bits [6:4] pick the hardware load/clear source. 0 is none; 1 clears on the next reference; 2 clears on every reference; 3 clears on a timer tick; 4 loads on the next reference; 5 loads on every reference; 6 is described in R13; 7 loads on the external load strobe. Strobes from sources that are not selected have no effect.
- R11: Mode bits [9:7] (capture 0) and [12:10] (capture 1) pick a capture source. 0 is none, 1 the software sync strobe, 2 the timer tick, 3 the sync input, 4 the external capture strobe, 5 the next reference, 6 the second reference, and 7 every reference. Control bits 2 and 3 capture by software. A capture stores the count held before that clock edge, and it can be read one cycle later through `rd_data`.
- R12: Control bit 4 arms the sequencer. The first accepted reference after the arm is the "next" reference, and the second one is the "second" reference, after which the sequencer disarms. Without an arm, next/second sources never fire, while every-reference sources fire regardless.
- R13: Load/clear source 6 clears the count on every reference. It also replaces a down step taken from a count of 0 with a copy of the load register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trk_a | input | 1 | Track A (direction in mode 0) |
| trk_b | input | 1 | Track B (count clock in mode 0) |
| trk_c | input | 1 | Reference / strobe track |
| timer_tick | input | 1 | Timer zero-crossing strobe |
| sync_in | input | 1 | External sync strobe |
| sw_sync | input | 1 | Software sync strobe |
| ext_load | input | 1 | External load strobe |
| ext_latch | input | 1 | External capture strobe |
| mode_we | input | 1 | Mode word write enable |
| mode_wdata | input | 13 | Mode word |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control command bits |
| load_we | input | 1 | Load register word write enable |
| load_word | input | 1 | Load register word index |
| load_wdata | input | 16 | Load register word data |
| rd_latch | input | 1 | Capture register select |
| rd_word | input | 1 | Capture register word index |
| rd_data | output | 16 | Selected capture word |
| count | output | 32 | Current count |

## Verification
The bench walks the tracks through full forward and backward periods in each evaluation mode. The totals (4, 2 or 1 per period) tell the three quadrature modes apart, and a double-track jump shows that illegal steps are dropped. Reference pulses are given at the accepting quadrant and at a rejecting one, with A/B inversion off and on, and in mode 0. This separates quadrant gating from plain C edges. Armed and unarmed reference runs, with different load values before and after software loads, show which reference mark each source acted on. Every hardware source is strobed against counts that differ from the prior capture contents.

// File: rtl/qc_pkg.sv
package qc_pkg;

    typedef enum logic [1:0] {
        EV_CLKDIR = 2'd0,
        EV_X1     = 2'd1,
        EV_X2     = 2'd2,
        EV_X4     = 2'd3
    } eval_e;

    typedef enum logic [2:0] {
        LD_OFF       = 3'd0,
        LD_CLR_NEXT  = 3'd1,
        LD_CLR_ALL   = 3'd2,
        LD_CLR_TMR   = 3'd3,
        LD_LOAD_NEXT = 3'd4,
        LD_LOAD_ALL  = 3'd5,
        LD_CLR_WRAP  = 3'd6,
        LD_LOAD_EXT  = 3'd7
    } ldsrc_e;

    typedef enum logic [2:0] {
        LT_OFF    = 3'd0,
        LT_SW     = 3'd1,
        LT_TMR    = 3'd2,
        LT_SYNC   = 3'd3,
        LT_EXT    = 3'd4,
        LT_NEXT   = 3'd5,
        LT_SECOND = 3'd6,
        LT_ALL    = 3'd7
    } ltsrc_e;

    // Mode word, LSB first: eval, dir_inv, ab_inv, ldsel, lat0, lat1
    typedef struct packed {
        ltsrc_e lat1;
        ltsrc_e lat0;
        ldsrc_e ldsel;
        logic   ab_inv;
        logic   dir_inv;
        eval_e  eval;
    } mode_t;

    typedef struct packed {
        logic ref_arm;
        logic cap1;
        logic cap0;
        logic load;
        logic clr;
    } ctl_t;

    typedef struct packed {
        logic step;
        logic up;
        logic ref_ev;
    } dec_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int CTL_W  = $bits(ctl_t);

    // Position of an (A,B) pair along the forward cycle 00,10,11,01
    function automatic logic [1:0] gray_pos(input logic a, input logic b);
        case ({a, b})
            2'b00:   gray_pos = 2'd0;
            2'b10:   gray_pos = 2'd1;
            2'b11:   gray_pos = 2'd2;
            default: gray_pos = 2'd3;
        endcase
    endfunction

    function automatic logic cap_fire(input ltsrc_e sel, input logic sw, input logic tmr,
                                      input logic sync, input logic ext, input logic nxt,
                                      input logic sec, input logic all);
        case (sel)
            LT_SW:     cap_fire = sw;
            LT_TMR:    cap_fire = tmr;
            LT_SYNC:   cap_fire = sync;
            LT_EXT:    cap_fire = ext;
            LT_NEXT:   cap_fire = nxt;
            LT_SECOND: cap_fire = sec;
            LT_ALL:    cap_fire = all;
            default:   cap_fire = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/qc_decoder.sv
module qc_decoder
    import qc_pkg::*;
(
    input  logic  clk,
    input  logic  trk_a,
    input  logic  trk_b,
    input  logic  trk_c,
    input  eval_e eval,
    input  logic  dir_inv,
    input  logic  ab_inv,
    output dec_t  dec
);
    logic prev_a, prev_b, prev_c;

    // Raw levels are kept; inversion is applied to both sides with the current mode
    always_ff @(posedge clk) begin
        prev_a <= trk_a;
        prev_b <= trk_b;
        prev_c <= trk_c;
    end

    logic       ca, cb, pa, pb;
    logic [1:0] ppos, cpos, delta;
    logic       fwd, rev, a_moved, low_pair, dir_fwd;

    always_comb begin
        ca       = trk_a ^ ab_inv;
        cb       = trk_b ^ ab_inv;
        pa       = prev_a ^ ab_inv;
        pb       = prev_b ^ ab_inv;
        ppos     = gray_pos(pa, pb);
        cpos     = gray_pos(ca, cb);
        delta    = cpos - ppos;
        fwd      = (delta == 2'd1);
        rev      = (delta == 2'd3);
        a_moved  = (ca != pa);
        low_pair = ((ppos == 2'd0) && (cpos == 2'd1)) || ((ppos == 2'd1) && (cpos == 2'd0));

        dec.step = 1'b0;
        dir_fwd  = fwd;
        case (eval)
            EV_CLKDIR: begin
                dec.step = cb & ~pb;
                dir_fwd  = ~ca;
            end
            EV_X1:   dec.step = (fwd | rev) & low_pair;
            EV_X2:   dec.step = (fwd | rev) & a_moved;
            default: dec.step = fwd | rev;
        endcase
        dec.up     = dir_fwd ^ dir_inv;
        dec.ref_ev = trk_c & ~prev_c & ((eval == EV_CLKDIR) | (ca & cb));
    end

endmodule

// File: rtl/qc_refseq.sv
module qc_refseq (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic ref_ev,
    output logic first_hit,
    output logic second_hit,
    output logic armed
);
    logic seen_one;

    assign first_hit  = armed & ref_ev & ~seen_one;
    assign second_hit = armed & ref_ev & seen_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            seen_one <= 1'b0;
        end else if (arm) begin
            armed    <= 1'b1;
            seen_one <= 1'b0;
        end else if (second_hit) begin
            armed    <= 1'b0;
        end else if (first_hit) begin
            seen_one <= 1'b1;
        end
    end

endmodule

// File: rtl/qc_srcsel.sv
module qc_srcsel
    import qc_pkg::*;
(
    input  mode_t      mode,
    input  logic       ref_ev,
    input  logic       first_hit,
    input  logic       second_hit,
    input  logic       timer_tick,
    input  logic       sync_in,
    input  logic       sw_sync,
    input  logic       ext_load,
    input  logic       ext_latch,
    output logic       hw_clr,
    output logic       hw_load,
    output logic       wrap_en,
    output logic [1:0] cap_hit
);
    always_comb begin
        hw_clr  = 1'b0;
        hw_load = 1'b0;
        wrap_en = 1'b0;
        case (mode.ldsel)
            LD_CLR_NEXT:  hw_clr  = first_hit;
            LD_CLR_ALL:   hw_clr  = ref_ev;
            LD_CLR_TMR:   hw_clr  = timer_tick;
            LD_LOAD_NEXT: hw_load = first_hit;
            LD_LOAD_ALL:  hw_load = ref_ev;
            LD_CLR_WRAP: begin
                hw_clr  = ref_ev;
                wrap_en = 1'b1;
            end
            LD_LOAD_EXT:  hw_load = ext_load;
            default: ;
        endcase
        cap_hit[0] = cap_fire(mode.lat0, sw_sync, timer_tick, sync_in, ext_latch,
                              first_hit, second_hit, ref_ev);
        cap_hit[1] = cap_fire(mode.lat1, sw_sync, timer_tick, sync_in, ext_latch,
                              first_hit, second_hit, ref_ev);
    end

endmodule

// File: rtl/qc_channel.sv
module qc_channel
    import qc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int WORD_W = 16,
    localparam int NWORDS = CNT_W / WORD_W,
    localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trk_a,
    input  logic              trk_b,
    input  logic              trk_c,
    input  logic              timer_tick,
    input  logic              sync_in,
    input  logic              sw_sync,
    input  logic              ext_load,
    input  logic              ext_latch,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              load_we,
    input  logic [SEL_W-1:0]  load_word,
    input  logic [WORD_W-1:0] load_wdata,
    input  logic              rd_latch,
    input  logic [SEL_W-1:0]  rd_word,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count
);
    localparam int NCAP = 2;

    mode_t            mode_q;
    ctl_t             ctl;
    dec_t             dec;
    logic [CNT_W-1:0] count_q, count_d, load_q;
    logic [CNT_W-1:0] latch_q [NCAP];
    logic [WORD_W-1:0] cap_words [NCAP][NWORDS];
    logic             first_hit, second_hit, armed;
    logic             hw_clr, hw_load, wrap_en, wrap_hit;
    logic [1:0]       cap_hit;
    logic [NCAP-1:0]  cap_take;

    assign ctl = ctl_we ? ctl_t'(ctl_wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= '0;
        else if (mode_we) mode_q <= mode_t'(mode_wdata);
    end

    qc_decoder u_dec (
        .clk     (clk),
        .trk_a   (trk_a),
        .trk_b   (trk_b),
        .trk_c   (trk_c),
        .eval    (mode_q.eval),
        .dir_inv (mode_q.dir_inv),
        .ab_inv  (mode_q.ab_inv),
        .dec     (dec)
    );

    qc_refseq u_seq (
        .clk        (clk),
        .rst        (rst),
        .arm        (ctl.ref_arm),
        .ref_ev     (dec.ref_ev),
        .first_hit  (first_hit),
        .second_hit (second_hit),
        .armed      (armed)
    );

    qc_srcsel u_sel (
        .mode       (mode_q),
        .ref_ev     (dec.ref_ev),
        .first_hit  (first_hit),
        .second_hit (second_hit),
        .timer_tick (timer_tick),
        .sync_in    (sync_in),
        .sw_sync    (sw_sync),
        .ext_load   (ext_load),
        .ext_latch  (ext_latch),
        .hw_clr     (hw_clr),
        .hw_load    (hw_load),
        .wrap_en    (wrap_en),
        .cap_hit    (cap_hit)
    );

    // Load register, written one word at a time
    for (genvar w = 0; w < NWORDS; w++) begin : g_ldw
        always_ff @(posedge clk) begin
            if (rst)
                load_q[w*WORD_W +: WORD_W] <= '0;
            else if (load_we && (load_word == SEL_W'(w)))
                load_q[w*WORD_W +: WORD_W] <= load_wdata;
        end
    end

    assign wrap_hit = wrap_en & dec.step & ~dec.up & (count_q == '0);

    always_comb begin
        if (ctl.clr)                count_d = '0;
        else if (ctl.load)          count_d = load_q;
        else if (hw_clr)            count_d = '0;
        else if (hw_load | wrap_hit) count_d = load_q;
        else if (dec.step)          count_d = dec.up ? count_q + CNT_W'(1) : count_q - CNT_W'(1);
        else                        count_d = count_q;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count    = count_q;
    assign cap_take = {ctl.cap1 | cap_hit[1], ctl.cap0 | cap_hit[0]};

    for (genvar i = 0; i < NCAP; i++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)              latch_q[i] <= '0;
            else if (cap_take[i]) latch_q[i] <= count_q;
        end
        for (genvar w = 0; w < NWORDS; w++) begin : g_w
            assign cap_words[i][w] = latch_q[i][w*WORD_W +: WORD_W];
        end
    end

    assign rd_data = cap_words[rd_latch][rd_word];

endmodule

// File: rtl/qc_channel_chk.sv
module qc_channel_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             trk_a,
    input logic             trk_b,
    input logic             trk_c,
    input logic [1:0]       eval,
    input logic             ctl_we,
    input logic [4:0]       ctl_wdata,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] latch0,
    input logic             step,
    input logic             ref_ev,
    input logic             hw_clr,
    input logic             hw_load,
    input logic             wrap_hit,
    input logic             armed,
    input logic             second_hit
);
    // R8: software clear zeroes the count on the next cycle
    p_sw_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[0]) |=> (count == '0));

    // R8: with no step and no command the count holds (load writes included)
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!step && !(ctl_we && (ctl_wdata[0] || ctl_wdata[1])) && !hw_clr && !hw_load && !wrap_hit)
        |=> (count == $past(count)));

    // R5: double-track jump in a quadrature mode never steps
    p_bad_jump_r5: assert property (@(posedge clk) disable iff (rst)
        ((eval != 2'd0) && (trk_a != $past(trk_a)) && (trk_b != $past(trk_b))) |-> !step);

    // R11: software capture 0 stores the count held before the edge
    p_sw_cap_r11: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[2]) |=> (latch0 == $past(count)));

    // R7: a reference needs a rising edge on C
    p_ref_edge_r7: assert property (@(posedge clk) disable iff (rst)
        ref_ev |-> (trk_c && !$past(trk_c)));

    // R12: the sequencer disarms after the second reference
    p_disarm_r12: assert property (@(posedge clk) disable iff (rst)
        (second_hit && !(ctl_we && ctl_wdata[4])) |=> !armed);

endmodule

bind qc_channel qc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trk_a      (trk_a),
    .trk_b      (trk_b),
    .trk_c      (trk_c),
    .eval       (mode_q.eval),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .count      (count),
    .latch0     (latch_q[0]),
    .step       (dec.step),
    .ref_ev     (dec.ref_ev),
    .hw_clr     (hw_clr),
    .hw_load    (hw_load),
    .wrap_hit   (wrap_hit),
    .armed      (armed),
    .second_hit (second_hit)
);

// File: tb/qc_channel_bench.sv
module qc_channel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trk_a = 0, trk_b = 0, trk_c = 0;
    logic        timer_tick = 0, sync_in = 0, sw_sync = 0, ext_load = 0, ext_latch = 0;
    logic        mode_we = 0;
    logic [12:0] mode_wdata = '0;
    logic        ctl_we = 0;
    logic [4:0]  ctl_wdata = '0;
    logic        load_we = 0;
    logic [0:0]  load_word = '0;
    logic [15:0] load_wdata = '0;
    logic        rd_latch = 0;
    logic [0:0]  rd_word = '0;
    logic [15:0] rd_data;
    logic [31:0] count;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    qc_channel u_qc_channel (
        .clk(clk), .rst(rst), .trk_a(trk_a), .trk_b(trk_b), .trk_c(trk_c),
        .timer_tick(timer_tick), .sync_in(sync_in), .sw_sync(sw_sync),
        .ext_load(ext_load), .ext_latch(ext_latch),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .load_we(load_we), .load_word(load_word), .load_wdata(load_wdata),
        .rd_latch(rd_latch), .rd_word(rd_word), .rd_data(rd_data), .count(count)
    );

    function automatic logic [12:0] mk(input int ev, input int dinv, input int abinv,
                                       input int ld, input int c0, input int c1);
        mk = {c1[2:0], c0[2:0], ld[2:0], abinv[0], dinv[0], ev[1:0]};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic trk(input logic a, input logic b, input logic c);
        trk_a = a; trk_b = b; trk_c = c;
        tick();
    endtask

    task automatic wr_mode(input logic [12:0] v);
        mode_we = 1; mode_wdata = v; tick(); mode_we = 0;
    endtask

    task automatic wr_ctl(input logic [4:0] v);
        ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0; ctl_wdata = '0;
    endtask

    task automatic wr_load(input logic [31:0] v);
        load_we = 1;
        load_word = 1'b0; load_wdata = v[15:0];  tick();
        load_word = 1'b1; load_wdata = v[31:16]; tick();
        load_we = 0;
    endtask

    task automatic get_cap(input logic idx, output logic [31:0] v);
        rd_latch = idx;
        rd_word = 1'b0; #1 v[15:0]  = rd_data;
        rd_word = 1'b1; #1 v[31:16] = rd_data;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; tick(); s = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 count in reset", count, 32'h0);
        rst = 0;
        tick();
        chk("R1 count after reset", count, 32'h0);
        get_cap(1'b0, v); chk("R1 capture0 after reset", v, 32'h0);
        get_cap(1'b1, v); chk("R1 capture1 after reset", v, 32'h0);
    endtask

    task automatic t_clkdir();
        for (int i = 0; i < 3; i++) begin
            trk(0, 1, 0);
            trk(0, 0, 0);
        end
        chk("R2 up on B rise with A low", count, 32'd3);
        trk(1, 0, 0);
        chk("R2 A edge alone no count", count, 32'd3);
        trk(1, 1, 0);
        chk("R2 down with A high", count, 32'd2);
        trk(1, 0, 0);
        wr_mode(mk(0, 1, 0, 0, 0, 0));
        trk(0, 1, 0);
        chk("R6 inverted direction", count, 32'd1);
        trk(0, 0, 0);
        wr_mode(mk(0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_x4();
        wr_ctl(5'b00001);
        wr_mode(mk(3, 0, 0, 0, 0, 0));
        trk(1, 0, 0);
        chk("R3 first step same edge", count, 32'd1);
        trk(1, 1, 0); trk(0, 1, 0); trk(0, 0, 0);
        chk("R3 4x forward period", count, 32'd4);
        trk(0, 1, 0); trk(1, 1, 0);
        chk("R3 4x backward steps", count, 32'd2);
        trk(0, 0, 0);
        chk("R5 double-track jump ignored", count, 32'd2);
        trk(1, 0, 0);
        chk("R5 counting resumes", count, 32'd3);
        trk(0, 0, 0);
    endtask

    task automatic t_x1x2();
        wr_ctl(5'b00001);
        wr_mode(mk(2, 0, 0, 0, 0, 0));
        trk(1, 0, 0); trk(1, 1, 0); trk(0, 1, 0); trk(0, 0, 0);
        chk("R4 2x forward period", count, 32'd2);
        wr_mode(mk(1, 0, 0, 0, 0, 0));
        trk(1, 0, 0); trk(1, 1, 0); trk(0, 1, 0); trk(0, 0, 0);
        chk("R4 1x forward period", count, 32'd3);
        trk(0, 1, 0); trk(1, 1, 0); trk(1, 0, 0); trk(0, 0, 0);
        chk("R4 1x backward period", count, 32'd2);
    endtask

    task automatic t_load_wrap();
        wr_mode(mk(0, 0, 0, 0, 0, 0));
        wr_ctl(5'b00001);
        wr_load(32'hFFFF_FFFF);
        chk("R8 load write leaves count", count, 32'h0);
        wr_ctl(5'b00010);
        chk("R8 software load", count, 32'hFFFF_FFFF);
        trk(0, 1, 0);
        chk("R9 wrap up", count, 32'h0);
        trk(1, 0, 0); trk(1, 1, 0);
        chk("R9 wrap down", count, 32'hFFFF_FFFF);
        trk(0, 0, 0);
        wr_ctl(5'b00011);
        chk("R8 clear beats load", count, 32'h0);
    endtask

    task automatic t_capture_sw();
        logic [31:0] v;
        wr_load(32'h1234_5678);
        wr_ctl(5'b00010);
        wr_ctl(5'b00100);
        get_cap(1'b0, v); chk("R11 software capture0", v, 32'h1234_5678);
        trk(0, 1, 0); trk(0, 0, 0);
        wr_ctl(5'b01000);
        get_cap(1'b1, v); chk("R11 software capture1", v, 32'h1234_5679);
        wr_ctl(5'b00101);
        get_cap(1'b0, v); chk("R11 capture holds pre-clear count", v, 32'h1234_5679);
        chk("R8 clear with capture", count, 32'h0);
    endtask

    task automatic t_quadrant();
        wr_mode(mk(3, 0, 0, 5, 0, 0));
        wr_load(32'h1234);
        trk(1, 0, 0); trk(1, 1, 0);
        trk(1, 1, 1);
        chk("R7 reference at A=B=1", count, 32'h1234);
        trk(1, 1, 0);
        trk(0, 1, 0);
        trk(0, 1, 1);
        chk("R7 reference rejected at A=0 B=1", count, 32'h1235);
        trk(0, 1, 0);
        trk(0, 0, 0);
        wr_mode(mk(3, 0, 1, 5, 0, 0));
        trk(0, 0, 1);
        chk("R7 inverted tracks accept at raw 00", count, 32'h1234);
        trk(0, 0, 0);
        wr_mode(mk(0, 0, 0, 5, 0, 0));
        wr_ctl(5'b00001);
        trk(0, 0, 1);
        chk("R7 mode 0 any C rise", count, 32'h1234);
        trk(0, 0, 0);
    endtask

    task automatic t_refseq();
        logic [31:0] v;
        wr_mode(mk(3, 0, 0, 4, 0, 6));
        trk(1, 0, 0); trk(1, 1, 0);
        chk("R3 back at 11", count, 32'h1236);
        wr_load(32'h50);
        trk(1, 1, 1);
        chk("R12 unarmed next ignored", count, 32'h1236);
        trk(1, 1, 0);
        wr_ctl(5'b10000);
        trk(1, 1, 1);
        chk("R12 next reference loads", count, 32'h50);
        get_cap(1'b1, v); chk("R12 second source idle on first", v, 32'h1234_5679);
        trk(1, 1, 0);
        wr_load(32'h77);
        wr_ctl(5'b00010);
        wr_load(32'h99);
        trk(1, 1, 1);
        chk("R12 next acts only once", count, 32'h77);
        get_cap(1'b1, v); chk("R12 second reference captures", v, 32'h77);
        trk(1, 1, 0);
        wr_ctl(5'b00010);
        trk(1, 1, 1);
        get_cap(1'b1, v); chk("R12 disarmed after second", v, 32'h77);
        trk(1, 1, 0);
    endtask

    task automatic t_sources();
        logic [31:0] v;
        wr_mode(mk(0, 0, 0, 3, 2, 4));
        pulse(timer_tick);
        tick();
        chk("R10 clear on timer", count, 32'h0);
        get_cap(1'b0, v); chk("R11 capture0 on timer", v, 32'h99);
        wr_load(32'h321);
        wr_ctl(5'b00010);
        pulse(ext_latch);
        get_cap(1'b1, v); chk("R11 capture1 on external strobe", v, 32'h321);
        wr_mode(mk(0, 0, 0, 7, 3, 1));
        pulse(sync_in);
        get_cap(1'b0, v); chk("R11 capture0 on sync input", v, 32'h321);
        wr_ctl(5'b00001);
        wr_load(32'h444);
        pulse(ext_load);
        chk("R10 load on external strobe", count, 32'h444);
        pulse(sw_sync);
        get_cap(1'b1, v); chk("R11 capture1 on software sync", v, 32'h444);
        pulse(timer_tick);
        chk("R10 unselected timer ignored", count, 32'h444);
        wr_mode(mk(0, 0, 0, 2, 7, 0));
        trk(1, 1, 1);
        chk("R10 clear on every reference", count, 32'h0);
        get_cap(1'b0, v); chk("R11 capture0 on every reference", v, 32'h444);
        trk(1, 1, 0);
    endtask

    task automatic t_zero_cross();
        wr_mode(mk(0, 0, 0, 6, 0, 0));
        wr_load(32'd100);
        wr_ctl(5'b00001);
        trk(1, 0, 0); trk(1, 1, 0);
        chk("R13 down from zero reloads", count, 32'd100);
        trk(1, 0, 0); trk(1, 1, 0);
        chk("R13 ordinary down step", count, 32'd99);
        trk(1, 1, 1);
        chk("R13 reference clears", count, 32'd0);
        trk(1, 1, 0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        t_clkdir();
        t_x4();
        t_x1x2();
        t_load_wrap();
        t_capture_sw();
        t_quadrant();
        t_refseq();
        t_sources();
        t_zero_cross();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule